// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Hardware Refill

This block caches virtual-to-physical page translations for one requester. A 32-bit virtual address uses 4 KB pages. The block returns a 36-bit physical address: a 24-bit frame number placed above the unchanged 12-bit offset. Each of the eight fully associative entries is tagged with a 19-bit virtual page number and the 8-bit address-space identifier (ASID) that was current when the entry was filled. A global flag in the entry makes the ASID compare irrelevant. Each entry also holds a dirty flag and three coherence attribute bits.

A lookup that misses does not trap to software. A built-in walker issues one read to a flat page table held in memory, at the table base plus four times the page number. It waits for the 32-bit table word, installs it, and completes the translation. While the walk is in progress the block holds off new requests.

Software can invalidate every entry at once, or only the non-global entries that belong to one ASID. Fault codes report three cases: a user access to the kernel half of the address space, a table word marked not valid, and a store to a page whose dirty flag is still clear.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: An accepted request hits an entry that is valid, has an equal page number (`req_va[30:12]`), and is either global or carries an ASID equal to `cur_asid`. On a hit, `rsp_valid` is 1 in the cycle after acceptance, with `rsp_pa = {pfn, req_va[11:0]}` and no memory read.
- R3: On a miss, `req_ready` goes low and `mem_req_valid` is held with `mem_req_addr = pt_base + 4*req_va[30:12]` until `mem_rsp_valid`. The response follows one cycle after `mem_rsp_valid`.
- R4: The table word has this layout: frame number in bits [23:0], valid in bit 24, dirty in bit 25, global in bit 26, and coherence attributes in bits [29:27]. The coherence bits of the entry used are reported on `rsp_coh`.
- R5: A table word with bit 24 clear ends the request with fault code 1 and `rsp_pa` 0. Nothing is installed, so a repeat of the same request walks again.
- R6: A request with `req_user` 1 and `req_va[31]` 1 ends with fault code 2 in the next cycle and starts no walk. A request with `req_user` 0 translates such an address normally.
- R7: A non-global entry matches only while `cur_asid` equals the ASID latched at refill. A global entry matches under any ASID.
- R8: A store that uses an entry whose dirty flag is clear reports fault code 3, together with the translated address. This applies both on a hit and on refill completion. Otherwise the fault code is 0.
- R9: A refill uses the lowest-numbered invalid entry if one exists. When all entries are valid, it replaces the entry at a round-robin pointer, which starts at 0 and advances by one after each such replacement.
- R10: A one-cycle `flush_all` pulse invalidates every entry.
- R11: A one-cycle `flush_asid_en` pulse invalidates exactly the non-global entries whose ASID equals `flush_asid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | 32 | Virtual address |
| req_user | input | 1 | Request comes from user mode |
| req_store | input | 1 | Request is a store |
| cur_asid | input | 8 | Current address-space identifier |
| pt_base | input | 36 | Byte address of the page table |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_pa | output | 36 | Physical address |
| rsp_coh | output | 3 | Coherence attributes of the page |
| rsp_fault | output | 2 | 0 none, 1 page, 2 protection, 3 dirty |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate non-global entries of flush_asid |
| flush_asid | input | 8 | ASID to invalidate |
| mem_req_valid | output | 1 | Page-table read pending |
| mem_req_addr | output | 36 | Page-table word address |
| mem_rsp_valid | input | 1 | Page-table word returned |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
A hit or a protection fault is registered at the accepting edge, so the bench samples `rsp_valid`, `rsp_pa`, `rsp_coh` and `rsp_fault` at the falling edge right after that edge. On a miss, `mem_req_valid` is observed at that same falling edge. The bench then holds the table word back for two more cycles and checks that the read stays posted. It drives `mem_rsp_valid` for one cycle and samples the response at the next falling edge. Flush pulses last one cycle, and their effect is judged through whether the following request walks.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 24,
  parameter int ASID_W  = 8,
  parameter int COH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VPN_W+OFF_W:0]     req_va,
  input  logic                     req_user,
  input  logic                     req_store,
  input  logic [ASID_W-1:0]        cur_asid,
  input  logic [PFN_W+OFF_W-1:0]   pt_base,
  output logic                     rsp_valid,
  output logic [PFN_W+OFF_W-1:0]   rsp_pa,
  output logic [COH_W-1:0]         rsp_coh,
  output logic [1:0]               rsp_fault,
  input  logic                     flush_all,
  input  logic                     flush_asid_en,
  input  logic [ASID_W-1:0]        flush_asid,
  output logic                     mem_req_valid,
  output logic [PFN_W+OFF_W-1:0]   mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [31:0]              mem_rsp_data
);
  localparam int VA_W  = VPN_W + OFF_W + 1;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int B_V   = PFN_W;
  localparam int B_D   = PFN_W + 1;
  localparam int B_G   = PFN_W + 2;
  localparam int B_C   = PFN_W + 3;
  localparam logic [1:0] F_NONE = 2'd0, F_PAGE = 2'd1, F_PROT = 2'd2, F_DIRTY = 2'd3;

  logic [ENTRIES-1:0] e_v, e_g, e_d;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [COH_W-1:0]   e_coh  [ENTRIES];

  logic               walking;
  logic [VPN_W-1:0]   q_vpn;
  logic [OFF_W-1:0]   q_off;
  logic [ASID_W-1:0]  q_asid;
  logic               q_store;
  logic [IDX_W-1:0]   rr;

  logic               hit, free;
  logic [IDX_W-1:0]   hit_idx, free_idx, victim;

  wire [VPN_W-1:0] in_vpn = req_va[VA_W-2:OFF_W];
  wire accept = req_valid && !walking;
  wire prot   = req_user && req_va[VA_W-1];
  wire fill   = walking && mem_rsp_valid;
  wire pte_ok = mem_rsp_data[B_V];

  assign req_ready     = !walking;
  assign mem_req_valid = walking;
  assign mem_req_addr  = pt_base + PA_W'({q_vpn, 2'b00});
  assign victim        = free ? free_idx : rr;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && e_v[i] && e_vpn[i] == in_vpn && (e_g[i] || e_asid[i] == cur_asid)) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!free && !e_v[i]) begin
        free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_coh   <= '0;
      rsp_fault <= F_NONE;
      e_v       <= '0;
      rr        <= '0;
      q_vpn     <= '0;
      q_off     <= '0;
      q_asid    <= '0;
      q_store   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (prot) begin
          rsp_valid <= 1'b1;
          rsp_pa    <= '0;
          rsp_coh   <= '0;
          rsp_fault <= F_PROT;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_pa    <= {e_pfn[hit_idx], req_va[OFF_W-1:0]};
          rsp_coh   <= e_coh[hit_idx];
          rsp_fault <= (req_store && !e_d[hit_idx]) ? F_DIRTY : F_NONE;
        end else begin
          walking <= 1'b1;
          q_vpn   <= in_vpn;
          q_off   <= req_va[OFF_W-1:0];
          q_asid  <= cur_asid;
          q_store <= req_store;
        end
      end
      if (fill) begin
        walking   <= 1'b0;
        rsp_valid <= 1'b1;
        if (pte_ok) begin
          rsp_pa    <= {mem_rsp_data[PFN_W-1:0], q_off};
          rsp_coh   <= mem_rsp_data[B_C +: COH_W];
          rsp_fault <= (q_store && !mem_rsp_data[B_D]) ? F_DIRTY : F_NONE;
          e_v[victim] <= 1'b1;
          if (!free) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
        end else begin
          rsp_pa    <= '0;
          rsp_coh   <= '0;
          rsp_fault <= F_PAGE;
        end
      end
      if (flush_all) begin
        e_v <= '0;
      end else if (flush_asid_en) begin
        for (int i = 0; i < ENTRIES; i++)
          if (!e_g[i] && e_asid[i] == flush_asid) e_v[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill && pte_ok) begin
      e_vpn[victim]  <= q_vpn;
      e_pfn[victim]  <= mem_rsp_data[PFN_W-1:0];
      e_asid[victim] <= q_asid;
      e_coh[victim]  <= mem_rsp_data[B_C +: COH_W];
      e_g[victim]    <= mem_rsp_data[B_G];
      e_d[victim]    <= mem_rsp_data[B_D];
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 36,
  parameter int PFN_W = 24,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_va,
  input logic             req_user,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [1:0]       rsp_fault,
  input logic             mem_req_valid,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [31:0]      mem_rsp_data
);
  a_r3_walk_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past((req_valid && req_ready) || (mem_req_valid && mem_rsp_valid)));

  a_r6_prot_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_user && req_va[VA_W-1])
      |=> (rsp_valid && rsp_fault == 2'd2 && !mem_req_valid));

  a_r5_bad_word_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid && !mem_rsp_data[PFN_W])
      |=> (rsp_valid && rsp_fault == 2'd1));

  a_r4_fill_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid && mem_rsp_data[PFN_W])
      |=> (rsp_valid && rsp_pa[PA_W-1:OFF_W] == $past(mem_rsp_data[PFN_W-1:0])));
endmodule

bind asid_tlb asid_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_user(req_user), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_store = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [7:0]  cur_asid = 8'd1;
  logic [35:0] pt_base = 36'h0_8000_0000;
  logic        rsp_valid;
  logic [35:0] rsp_pa;
  logic [2:0]  rsp_coh;
  logic [1:0]  rsp_fault;
  logic        flush_all = 1'b0, flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;
  logic        mem_req_valid;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_user(req_user), .req_store(req_store), .cur_asid(cur_asid),
    .pt_base(pt_base), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_coh(rsp_coh),
    .rsp_fault(rsp_fault), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_asid(flush_asid), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Table word per page: frame, valid unless low nibble is F, dirty on odd pages,
  // global when bits [7:4] are 9, coherence from bits [3:1].
  function automatic logic [31:0] pte_of(logic [18:0] vpn);
    logic [23:0] pfn = 24'h800000 | 24'(vpn * 7);
    return {2'b00, vpn[3:1], vpn[7:4] == 4'h9, vpn[0], vpn[3:0] != 4'hF, pfn};
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic req(logic [18:0] vpn, logic [11:0] off, bit k, bit user, bit store,
                     logic [7:0] asid, bit exp_walk, logic [1:0] exp_fault, string rq);
    logic [31:0] pte = pte_of(vpn);
    logic [35:0] exp_pa;
    bit walked = 1'b0;
    exp_pa = (exp_fault == 2'd1 || exp_fault == 2'd2) ? 36'h0 : {pte[23:0], off};
    @(negedge clk);
    chk(req_ready, rq, "ready before request", 64'(req_ready), 64'd1);
    cur_asid = asid; req_valid = 1'b1; req_va = {k, vpn, off};
    req_user = user; req_store = store;
    @(negedge clk);
    req_valid = 1'b0;
    if (mem_req_valid) begin
      walked = 1'b1;
      chk(mem_req_addr == pt_base + 36'({vpn, 2'b00}), rq, "walk address",
          64'(mem_req_addr), 64'(pt_base + 36'({vpn, 2'b00})));
      chk(!req_ready, rq, "ready during walk", 64'(req_ready), 64'd0);
      repeat (2) @(negedge clk);
      chk(mem_req_valid, rq, "read held", 64'(mem_req_valid), 64'd1);
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    chk(walked == exp_walk, rq, "walk taken", 64'(walked), 64'(exp_walk));
    chk(rsp_valid, rq, "response strobe", 64'(rsp_valid), 64'd1);
    chk(rsp_fault == exp_fault, rq, "fault code", 64'(rsp_fault), 64'(exp_fault));
    chk(rsp_pa == exp_pa, rq, "physical address", 64'(rsp_pa), 64'(exp_pa));
    if (exp_fault == 2'd0 || exp_fault == 2'd3)
      chk(rsp_coh == pte[29:27], "R4", "coherence bits", 64'(rsp_coh), 64'(pte[29:27]));
  endtask

  task automatic pulse_flush(bit all, logic [7:0] asid);
    @(negedge clk);
    flush_all = all; flush_asid_en = !all; flush_asid = asid;
    @(negedge clk);
    flush_all = 1'b0; flush_asid_en = 1'b0;
  endtask

  typedef struct packed {
    logic [18:0] vpn;
    logic [11:0] off;
    logic        k, user, store;
    logic [7:0]  asid;
    logic        walk;
    logic [1:0]  fault;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{19'h10, 12'h123, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 2'd0},  // R3 cold miss
    '{19'h10, 12'hABC, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 2'd0},  // R2 hit
    '{19'h10, 12'h004, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, 2'd3},  // R8 store clean hit
    '{19'h11, 12'h008, 1'b0, 1'b0, 1'b1, 8'd1, 1'b1, 2'd0},  // R8 store dirty refill
    '{19'h11, 12'hFFC, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, 2'd0},  // R8 store dirty hit
    '{19'h10, 12'h010, 1'b0, 1'b0, 1'b0, 8'd2, 1'b1, 2'd0},  // R7 other ASID misses
    '{19'h10, 12'h020, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 2'd0},  // R7 own ASID hits
    '{19'h90, 12'h030, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 2'd0},  // R7 global refill
    '{19'h90, 12'h040, 1'b0, 1'b0, 1'b0, 8'd5, 1'b0, 2'd0},  // R7 global any ASID
    '{19'h1F, 12'h050, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 2'd1},  // R5 invalid word
    '{19'h1F, 12'h060, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 2'd1},  // R5 not installed
    '{19'h10, 12'h070, 1'b1, 1'b1, 1'b0, 8'd1, 1'b0, 2'd2},  // R6 user kernel address
    '{19'h10, 12'h080, 1'b1, 1'b0, 1'b0, 8'd1, 1'b0, 2'd0},  // R6 kernel mode allowed
    '{19'h10, 12'h090, 1'b0, 1'b1, 1'b0, 8'd1, 1'b0, 2'd0}   // R2 user low half
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1", "no read after reset", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++)
      req(VECS[i].vpn, VECS[i].off, VECS[i].k, VECS[i].user, VECS[i].store,
          VECS[i].asid, VECS[i].walk, VECS[i].fault, "R2/R3 vector");

    pulse_flush(1'b0, 8'd2);
    req(19'h10, 12'h100, 0, 0, 0, 8'd2, 1'b1, 2'd0, "R11");
    req(19'h10, 12'h104, 0, 0, 0, 8'd1, 1'b0, 2'd0, "R11");
    req(19'h90, 12'h108, 0, 0, 0, 8'd2, 1'b0, 2'd0, "R11");
    pulse_flush(1'b0, 8'd1);
    req(19'h90, 12'h10C, 0, 0, 0, 8'd1, 1'b0, 2'd0, "R11");
    req(19'h11, 12'h110, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R11");

    pulse_flush(1'b1, 8'd0);
    req(19'h90, 12'h200, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R10");
    req(19'h10, 12'h204, 0, 0, 0, 8'd2, 1'b1, 2'd0, "R10");

    pulse_flush(1'b1, 8'd0);
    for (int v = 0; v < 8; v++)
      req(19'h20 + 19'(v), 12'h300, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R9");
    req(19'h28, 12'h304, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R9");
    req(19'h21, 12'h308, 0, 0, 0, 8'd1, 1'b0, 2'd0, "R9");
    req(19'h20, 12'h30C, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R9");
    req(19'h21, 12'h310, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R9");
    req(19'h23, 12'h314, 0, 0, 0, 8'd1, 1'b0, 2'd0, "R9");
    req(19'h22, 12'h318, 0, 0, 0, 8'd1, 1'b1, 2'd0, "R9");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule